// File: doc/BRIEF.md
# I2C memory transaction controller

This block sequences complete memory-style transactions on an I2C bus. It sits above a bit-level engine that performs single bus operations (START condition, STOP condition, one byte written with its acknowledge sampled, one byte read with an acknowledge bit returned). A host pulses `start` with an operation code, a 7-bit device address, a register address of zero to `ADDR_BYTES` bytes, and a byte count. The controller then issues one engine command at a time. Each command is a single-cycle `eng_cmd_valid` pulse. The controller waits for the matching `eng_done` pulse and checks the acknowledge before it picks the next command.

Three operations are supported: probe, register read and register write. Reads with a non-zero register-address length first run an address-setting write phase. A configuration input then chooses how the bus turns around: a repeated START alone, or STOP followed by START. When folding is enabled, register-address bits above the configured length are masked and merged into the device address. This lets one large memory answer as several 256-byte devices. Write data is pulled through a take strobe and read data is pushed with a valid strobe. The result appears with a one-cycle `done` pulse: an error flag, a device-present flag, and a count of data bytes that were not acknowledged.

States: IDLE, START (opening START), DEVW (device byte with write bit), REGA (register-address bytes), TSTOP (turnaround STOP), TSTART (turnaround START), DEVR (device byte with read bit), WDATA (write data bytes), RDATA (read data bytes), STOP (closing STOP), DONE (status pulse). Transitions:
- IDLE→START on `start`.
- START→DEVR for a read with length 0, otherwise START→DEVW.
- DEVW→STOP on NACK or for a probe.
- DEVW→REGA when the length is non-zero.
- DEVW→WDATA or STOP for a write with length 0.
- REGA→DONE on NACK.
- REGA→REGA while address bytes remain.
- REGA→WDATA or STOP for a write.
- REGA→TSTART or TSTOP for a read.
- TSTOP→TSTART, and TSTART→DEVR.
- DEVR→RDATA, or DEVR→STOP when the count is 0.
- WDATA and RDATA loop, then go to STOP after the last byte.
- STOP→DONE, and DONE→IDLE.

Top module: `memxfer_ctrl`

## Requirements
- R1: Engine command codes are 0 START, 1 STOP, 2 WRITE byte, 3 READ byte. A probe (op 0, and also op 3) issues START, WRITE of {dev,0}, STOP. It reports present=1 when that byte is ACKed (`eng_nack`=0). It reports present=0 with error=0 when the byte is NACKed.
- R2: A write (op 2) issues START, WRITE {dev,0}, the register-address bytes most significant first, the data bytes in order, then STOP. `wr_take` pulses once per data byte, in the cycle that byte is issued.
- R3: If the device byte with the write bit is NACKed, in a write or in the address phase of a read, the next command is STOP and the status reports error=1.
- R4: If any register-address byte is NACKed, no further command is issued (no STOP), and `done` reports error=1.
- R5: A NACK on a write data byte does not stop the transfer. Each one increments the failure count, which is reported with `done` after the STOP.
- R6: A read (op 1) with a register-address length above 0 follows the address bytes with STOP then START when `turn_rs`=0. It follows them with START alone when `turn_rs`=1. Either way the next command is WRITE {dev,1}.
- R7: A read with a register-address length of 0 issues START and then WRITE {dev,1} at once, with no write phase.
- R8: Read data bytes are requested with acknowledge bit 0 (`eng_nack_out`=0), except the last, which uses 1. STOP follows the last byte. Each byte is delivered on `rd_data` with a `rd_valid` pulse. The acknowledge of the {dev,1} byte is ignored.
- R9: With `fold_en`=1, the device address sent is dev OR ((reg_addr >> 8·length) AND `fold_mask`). With `fold_en`=0 it is dev unchanged.
- R10: A write with a byte count of 0 issues only START, the device and register-address bytes, then STOP.
- R11: After reset the block is idle with no command or `done` pulse. `start` while busy is ignored, and `done` is a single-cycle pulse after which `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (ignored while busy) |
| op | input | 2 | 0 probe, 1 read, 2 write, 3 probe |
| dev_addr | input | 7 | Device address |
| reg_addr | input | ADDR_BYTES*8 | Register address |
| addr_len | input | AL_W | Register-address length in bytes (clamped to ADDR_BYTES) |
| byte_cnt | input | LEN_W | Number of data bytes |
| turn_rs | input | 1 | Read turnaround: 1 repeated START, 0 STOP then START |
| fold_en | input | 1 | Fold upper register-address bits into the device address |
| fold_mask | input | 7 | Mask for folded bits |
| wr_data | input | 8 | Next write data byte |
| wr_take | output | 1 | Write data byte consumed |
| rd_valid | output | 1 | Read data byte valid |
| rd_data | output | 8 | Read data byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Status valid pulse |
| st_err | output | 1 | Transaction aborted on address NACK |
| st_present | output | 1 | Probe found the device |
| st_fails | output | FAIL_W | Count of NACKed write data bytes |
| eng_cmd_valid | output | 1 | Command pulse to the bit engine |
| eng_cmd | output | 2 | Command code |
| eng_wdata | output | 8 | Byte to write |
| eng_nack_out | output | 1 | Acknowledge bit to send after a read byte |
| eng_done | input | 1 | Engine finished the command |
| eng_nack | input | 1 | Sampled acknowledge of a written byte (1 = NACK) |
| eng_rdata | input | 8 | Byte read by the engine |

## Verification
The engine model in the bench records every command. It answers each WRITE from a per-transaction NACK mask and returns a known byte pattern for each READ, so the full command log is compared with a sequence built from the requirements.

Probes are run with an ACKed and a NACKed address, which separates the present flag from the error flag. Writes are run with a multi-byte address, with data NACKs, with a NACK on the device byte, with a NACK on the middle address byte, and with a zero count. These show the difference between counting a failure, stopping with an error, and aborting without STOP.

Reads are run with both turnaround settings and with zero address length, with a NACK injected on the read-direction device byte. Folding is tried enabled and disabled on the same inputs. A second `start` is injected during a write to show it is ignored.

// File: rtl/memxfer_pkg.sv
package memxfer_pkg;

    typedef enum logic [1:0] {
        ENG_START = 2'd0,
        ENG_STOP  = 2'd1,
        ENG_WRITE = 2'd2,
        ENG_READ  = 2'd3
    } eng_cmd_e;

    typedef enum logic [1:0] {
        OP_PROBE = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_DEVW,
        ST_REGA,
        ST_TSTOP,
        ST_TSTART,
        ST_DEVR,
        ST_WDATA,
        ST_RDATA,
        ST_STOP,
        ST_DONE
    } state_e;

endpackage

// File: rtl/memxfer_devfold.sv
module memxfer_devfold #(
    parameter int ADDR_BYTES = 4,
    parameter int AL_W       = 3,
    localparam int ADDR_W    = ADDR_BYTES * 8
) (
    input  logic [6:0]        dev_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic [AL_W-1:0]   alen,
    input  logic              en,
    input  logic [6:0]        mask,
    output logic [6:0]        dev_out
);
    logic [6:0] upper;

    // Bits above the configured address bytes; a shift of the full width gives zero.
    assign upper   = 7'(addr >> {alen, 3'b000});
    assign dev_out = en ? (dev_in | (upper & mask)) : dev_in;

endmodule

// File: rtl/memxfer_bytesel.sv
module memxfer_bytesel #(
    parameter int ADDR_BYTES = 4,
    parameter int AL_W       = 3,
    localparam int ADDR_W    = ADDR_BYTES * 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [AL_W-1:0]   idx,
    output logic [7:0]        byte_out
);
    assign byte_out = 8'(addr >> {idx, 3'b000});
endmodule

// File: rtl/memxfer_ctrl.sv
module memxfer_ctrl
    import memxfer_pkg::*;
#(
    parameter int ADDR_BYTES = 4,
    parameter int AL_W       = $clog2(ADDR_BYTES + 1),
    parameter int LEN_W      = 8,
    parameter int FAIL_W     = 8,
    localparam int ADDR_W    = ADDR_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [6:0]        dev_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [AL_W-1:0]   addr_len,
    input  logic [LEN_W-1:0]  byte_cnt,
    input  logic              turn_rs,
    input  logic              fold_en,
    input  logic [6:0]        fold_mask,
    input  logic [7:0]        wr_data,
    output logic              wr_take,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic              st_err,
    output logic              st_present,
    output logic [FAIL_W-1:0] st_fails,
    output logic              eng_cmd_valid,
    output logic [1:0]        eng_cmd,
    output logic [7:0]        eng_wdata,
    output logic              eng_nack_out,
    input  logic              eng_done,
    input  logic              eng_nack,
    input  logic [7:0]        eng_rdata
);
    localparam logic [AL_W-1:0] ALEN_MAX = AL_W'(ADDR_BYTES);

    state_e               state_q, state_nx;
    op_e                  op_q, op_dec;
    logic                 pend_q;
    logic [6:0]           dev_q, dev_fold;
    logic [ADDR_W-1:0]    addr_q;
    logic [AL_W-1:0]      alen_q, alen_c, idx_q;
    logic [LEN_W-1:0]     left_q;
    logic                 rs_q;
    logic                 err_q, pres_q;
    logic [FAIL_W-1:0]    fail_q;
    logic                 rdv_q;
    logic [7:0]           rdd_q;
    logic [7:0]           reg_byte;
    logic                 step;

    assign alen_c = (addr_len > ALEN_MAX) ? ALEN_MAX : addr_len;
    assign step   = pend_q && eng_done;

    always_comb begin
        unique case (op)
            2'd1:    op_dec = OP_READ;
            2'd2:    op_dec = OP_WRITE;
            default: op_dec = OP_PROBE;
        endcase
    end

    memxfer_devfold #(.ADDR_BYTES(ADDR_BYTES), .AL_W(AL_W)) u_fold (
        .dev_in  (dev_addr),
        .addr    (reg_addr),
        .alen    (alen_c),
        .en      (fold_en),
        .mask    (fold_mask),
        .dev_out (dev_fold)
    );

    memxfer_bytesel #(.ADDR_BYTES(ADDR_BYTES), .AL_W(AL_W)) u_sel (
        .addr     (addr_q),
        .idx      (idx_q),
        .byte_out (reg_byte)
    );

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_nx = ST_START;
            ST_START:  if (step) state_nx = (op_q == OP_READ && alen_q == '0) ? ST_DEVR : ST_DEVW;
            ST_DEVW: begin
                if (step) begin
                    if (eng_nack || op_q == OP_PROBE) state_nx = ST_STOP;
                    else if (alen_q != '0)            state_nx = ST_REGA;
                    else if (left_q == '0)            state_nx = ST_STOP;
                    else                              state_nx = ST_WDATA;
                end
            end
            ST_REGA: begin
                if (step) begin
                    if (eng_nack)                 state_nx = ST_DONE;
                    else if (idx_q != '0)         state_nx = ST_REGA;
                    else if (op_q == OP_WRITE)    state_nx = (left_q == '0) ? ST_STOP : ST_WDATA;
                    else                          state_nx = rs_q ? ST_TSTART : ST_TSTOP;
                end
            end
            ST_TSTOP:  if (step) state_nx = ST_TSTART;
            ST_TSTART: if (step) state_nx = ST_DEVR;
            ST_DEVR:   if (step) state_nx = (left_q == '0) ? ST_STOP : ST_RDATA;
            ST_WDATA:  if (step && left_q == LEN_W'(1)) state_nx = ST_STOP;
            ST_RDATA:  if (step && left_q == LEN_W'(1)) state_nx = ST_STOP;
            ST_STOP:   if (step) state_nx = ST_DONE;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_PROBE;
            pend_q  <= 1'b0;
            dev_q   <= '0;
            addr_q  <= '0;
            alen_q  <= '0;
            idx_q   <= '0;
            left_q  <= '0;
            rs_q    <= 1'b0;
            err_q   <= 1'b0;
            pres_q  <= 1'b0;
            fail_q  <= '0;
            rdv_q   <= 1'b0;
            rdd_q   <= '0;
        end else begin
            state_q <= state_nx;
            rdv_q   <= 1'b0;
            if (eng_cmd_valid) pend_q <= 1'b1;
            else if (step)     pend_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q   <= op_dec;
                        dev_q  <= dev_fold;
                        addr_q <= reg_addr;
                        alen_q <= alen_c;
                        left_q <= byte_cnt;
                        rs_q   <= turn_rs;
                        err_q  <= 1'b0;
                        pres_q <= 1'b0;
                        fail_q <= '0;
                    end
                end
                ST_DEVW: begin
                    if (step) begin
                        if (eng_nack) begin
                            if (op_q != OP_PROBE) err_q <= 1'b1;
                        end else if (op_q == OP_PROBE) begin
                            pres_q <= 1'b1;
                        end
                        if (alen_q != '0) idx_q <= alen_q - 1'b1;
                    end
                end
                ST_REGA: begin
                    if (step) begin
                        if (eng_nack)          err_q <= 1'b1;
                        else if (idx_q != '0)  idx_q <= idx_q - 1'b1;
                    end
                end
                ST_WDATA: begin
                    if (step) begin
                        left_q <= left_q - 1'b1;
                        if (eng_nack && fail_q != '1) fail_q <= fail_q + 1'b1;
                    end
                end
                ST_RDATA: begin
                    if (step) begin
                        left_q <= left_q - 1'b1;
                        rdv_q  <= 1'b1;
                        rdd_q  <= eng_rdata;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        eng_cmd      = ENG_START;
        eng_wdata    = 8'h00;
        eng_nack_out = 1'b0;
        unique case (state_q)
            ST_START, ST_TSTART: eng_cmd = ENG_START;
            ST_STOP, ST_TSTOP:   eng_cmd = ENG_STOP;
            ST_DEVW:  begin eng_cmd = ENG_WRITE; eng_wdata = {dev_q, 1'b0}; end
            ST_DEVR:  begin eng_cmd = ENG_WRITE; eng_wdata = {dev_q, 1'b1}; end
            ST_REGA:  begin eng_cmd = ENG_WRITE; eng_wdata = reg_byte; end
            ST_WDATA: begin eng_cmd = ENG_WRITE; eng_wdata = wr_data; end
            ST_RDATA: begin eng_cmd = ENG_READ;  eng_nack_out = (left_q == LEN_W'(1)); end
            default: ;
        endcase
        eng_cmd_valid = !pend_q && (state_q != ST_IDLE) && (state_q != ST_DONE);
    end

    assign wr_take    = eng_cmd_valid && (state_q == ST_WDATA);
    assign rd_valid   = rdv_q;
    assign rd_data    = rdd_q;
    assign busy       = (state_q != ST_IDLE);
    assign done       = (state_q == ST_DONE);
    assign st_err     = err_q;
    assign st_present = pres_q;
    assign st_fails   = fail_q;

    // Assertions
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    a_r3_dev_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEVW && step && eng_nack) |=> (eng_cmd_valid && eng_cmd == ENG_STOP));

    a_r4_reg_nack_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REGA && step && eng_nack) |=> (done && st_err && !eng_cmd_valid));

    a_r5_fails_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (st_fails >= $past(st_fails)));

    a_r8_last_read_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RDATA && step && left_q == LEN_W'(1)) |=> (eng_cmd_valid && eng_cmd == ENG_STOP));

    a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(st_err && st_present));

endmodule

// File: tb/tb_memxfer_ctrl.sv
`timescale 1ns/1ps
module tb_memxfer_ctrl;
    localparam int ADDR_BYTES = 4;
    localparam int AL_W = 3;
    localparam int LEN_W = 8;
    localparam int FAIL_W = 8;
    localparam logic [9:0] C_START = 10'h000;
    localparam logic [9:0] C_STOP  = 10'h100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic [6:0]  dev_addr = '0;
    logic [31:0] reg_addr = '0;
    logic [2:0]  addr_len = '0;
    logic [7:0]  byte_cnt = '0;
    logic        turn_rs = 1'b0, fold_en = 1'b0;
    logic [6:0]  fold_mask = '0;
    logic [7:0]  wr_data;
    logic        wr_take, rd_valid, busy, done, st_err, st_present;
    logic [7:0]  rd_data;
    logic [FAIL_W-1:0] st_fails;
    logic        eng_cmd_valid, eng_nack_out;
    logic [1:0]  eng_cmd;
    logic [7:0]  eng_wdata;
    logic        eng_done = 1'b0, eng_nack = 1'b0;
    logic [7:0]  eng_rdata = '0;

    memxfer_ctrl #(.ADDR_BYTES(ADDR_BYTES), .AL_W(AL_W), .LEN_W(LEN_W), .FAIL_W(FAIL_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dev_addr(dev_addr),
        .reg_addr(reg_addr), .addr_len(addr_len), .byte_cnt(byte_cnt), .turn_rs(turn_rs),
        .fold_en(fold_en), .fold_mask(fold_mask), .wr_data(wr_data), .wr_take(wr_take),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done), .st_err(st_err),
        .st_present(st_present), .st_fails(st_fails), .eng_cmd_valid(eng_cmd_valid),
        .eng_cmd(eng_cmd), .eng_wdata(eng_wdata), .eng_nack_out(eng_nack_out),
        .eng_done(eng_done), .eng_nack(eng_nack), .eng_rdata(eng_rdata)
    );

    // Engine model and capture
    logic        clr = 1'b1;
    logic [15:0] nmask = '0;
    logic [7:0]  wbytes [0:15];
    logic [9:0]  log_q [0:31];
    logic [7:0]  rdbuf [0:15];
    int          nlog = 0, wcnt = 0, rcnt = 0, wk = 0, nrd = 0;
    logic        got_done = 1'b0, c_err = 1'b0, c_pres = 1'b0;
    logic [7:0]  c_fails = '0;
    logic        e_pend = 1'b0, e_nack_nx = 1'b0;
    logic [1:0]  e_dly = '0;
    logic [7:0]  e_rd_nx = '0;

    assign wr_data = wbytes[wk[3:0]];

    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (clr) begin
            nlog <= 0; wcnt <= 0; rcnt <= 0; wk <= 0; nrd <= 0;
            got_done <= 1'b0; e_pend <= 1'b0;
        end else begin
            if (eng_cmd_valid) begin
                if (nlog < 32)
                    log_q[nlog] <= {eng_cmd, (eng_cmd == 2'd3) ? {7'd0, eng_nack_out} :
                                             (eng_cmd == 2'd2) ? eng_wdata : 8'h00};
                nlog   <= nlog + 1;
                e_pend <= 1'b1;
                e_dly  <= 2'd2;
                e_nack_nx <= (eng_cmd == 2'd2) ? nmask[wcnt[3:0]] : 1'b0;
                if (eng_cmd == 2'd2) wcnt <= wcnt + 1;
                if (eng_cmd == 2'd3) begin
                    e_rd_nx <= 8'hA0 + 8'(rcnt);
                    rcnt    <= rcnt + 1;
                end
            end else if (e_pend) begin
                if (e_dly == 2'd0) begin
                    eng_done  <= 1'b1;
                    eng_nack  <= e_nack_nx;
                    eng_rdata <= e_rd_nx;
                    e_pend    <= 1'b0;
                end else begin
                    e_dly <= e_dly - 2'd1;
                end
            end
            if (wr_take) wk <= wk + 1;
            if (rd_valid) begin
                rdbuf[nrd[3:0]] <= rd_data;
                nrd <= nrd + 1;
            end
            if (done) begin
                got_done <= 1'b1;
                c_err    <= st_err;
                c_pres   <= st_present;
                c_fails  <= st_fails;
            end
        end
    end

    int total = 0, bad = 0;
    logic [9:0] exp_q [0:31];
    int nexp = 0;
    bit fin = 1'b0;

    task automatic chk(input string tag, input int act, input int expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic push(input logic [9:0] c);
        exp_q[nexp] = c;
        nexp++;
    endtask

    function automatic logic [9:0] cw(input logic [7:0] b);
        return {2'd2, b};
    endfunction

    function automatic logic [9:0] cr(input logic nk);
        return {2'd3, 7'd0, nk};
    endfunction

    task automatic cmp_log(input string tag);
        chk({tag, " command count"}, nlog, nexp);
        for (int i = 0; i < nexp; i++)
            chk({tag, " command"}, int'(log_q[i]), int'(exp_q[i]));
    endtask

    task automatic run(input logic [1:0] o, input logic [6:0] d, input logic [31:0] a,
                       input logic [2:0] al, input logic [7:0] n, input logic rs,
                       input logic fe, input logic [6:0] fm, input logic [15:0] nm,
                       input bit inject);
        int cyc;
        @(negedge clk); clr = 1'b1; nmask = nm;
        @(negedge clk); clr = 1'b0;
        op = o; dev_addr = d; reg_addr = a; addr_len = al; byte_cnt = n;
        turn_rs = rs; fold_en = fe; fold_mask = fm; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (inject) begin
            repeat (4) @(negedge clk);
            op = 2'd0; dev_addr = 7'h11; addr_len = 3'd0; byte_cnt = 8'd0; start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        cyc = 0;
        while (!got_done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        if (!got_done) begin
            total++; bad++;
            $display("FAIL R11 transaction watchdog actual=timeout expected=done");
        end
        repeat (3) @(negedge clk);
        nexp = 0;
    endtask

    // Scenarios
    task automatic t_reset();
        chk("R11 reset busy", int'(busy), 0);
        chk("R11 reset done", int'(done), 0);
        chk("R11 reset cmd", int'(eng_cmd_valid), 0);
    endtask

    task automatic t_probe_ack();
        run(2'd0, 7'h50, 32'h0, 3'd0, 8'd0, 1'b0, 1'b0, 7'h0, 16'h0000, 1'b0);
        push(C_START); push(cw(8'hA0)); push(C_STOP);
        cmp_log("R1 probe ack");
        chk("R1 present", int'(c_pres), 1);
        chk("R1 err", int'(c_err), 0);
    endtask

    task automatic t_probe_nack();
        run(2'd3, 7'h3C, 32'h0, 3'd0, 8'd0, 1'b0, 1'b0, 7'h0, 16'h0001, 1'b0);
        push(C_START); push(cw(8'h78)); push(C_STOP);
        cmp_log("R1 probe nack");
        chk("R1 absent", int'(c_pres), 0);
        chk("R1 absent err", int'(c_err), 0);
    endtask

    task automatic t_write_basic();
        wbytes[0] = 8'h11; wbytes[1] = 8'h22; wbytes[2] = 8'h33;
        run(2'd2, 7'h51, 32'h0000_1234, 3'd2, 8'd3, 1'b0, 1'b0, 7'h0, 16'h0000, 1'b1);
        push(C_START); push(cw(8'hA2)); push(cw(8'h12)); push(cw(8'h34));
        push(cw(8'h11)); push(cw(8'h22)); push(cw(8'h33)); push(C_STOP);
        cmp_log("R2 R11 write with busy start");
        chk("R2 take count", wk, 3);
        chk("R2 err", int'(c_err), 0);
        chk("R5 no fails", int'(c_fails), 0);
    endtask

    task automatic t_write_data_nack();
        wbytes[0] = 8'hC1; wbytes[1] = 8'hC2; wbytes[2] = 8'hC3; wbytes[3] = 8'hC4;
        run(2'd2, 7'h20, 32'h0000_0007, 3'd1, 8'd4, 1'b0, 1'b0, 7'h0, 16'b0010_1000, 1'b0);
        push(C_START); push(cw(8'h40)); push(cw(8'h07));
        push(cw(8'hC1)); push(cw(8'hC2)); push(cw(8'hC3)); push(cw(8'hC4)); push(C_STOP);
        cmp_log("R5 data nack");
        chk("R5 fail count", int'(c_fails), 2);
        chk("R5 err", int'(c_err), 0);
    endtask

    task automatic t_write_dev_nack();
        run(2'd2, 7'h50, 32'h0000_0055, 3'd1, 8'd2, 1'b0, 1'b0, 7'h0, 16'h0001, 1'b0);
        push(C_START); push(cw(8'hA0)); push(C_STOP);
        cmp_log("R3 device nack");
        chk("R3 err", int'(c_err), 1);
        chk("R3 no data taken", wk, 0);
    endtask

    task automatic t_write_reg_nack();
        run(2'd2, 7'h50, 32'h00AB_CDEF, 3'd3, 8'd2, 1'b0, 1'b0, 7'h0, 16'h0004, 1'b0);
        push(C_START); push(cw(8'hA0)); push(cw(8'hAB)); push(cw(8'hCD));
        cmp_log("R4 register nack no stop");
        chk("R4 err", int'(c_err), 1);
    endtask

    task automatic t_write_zero();
        run(2'd2, 7'h50, 32'h0000_0042, 3'd1, 8'd0, 1'b0, 1'b0, 7'h0, 16'h0000, 1'b0);
        push(C_START); push(cw(8'hA0)); push(cw(8'h42)); push(C_STOP);
        cmp_log("R10 zero count write");
        chk("R10 take count", wk, 0);
    endtask

    task automatic t_read_stop_start();
        run(2'd1, 7'h50, 32'h0000_0102, 3'd2, 8'd3, 1'b0, 1'b0, 7'h0, 16'h0000, 1'b0);
        push(C_START); push(cw(8'hA0)); push(cw(8'h01)); push(cw(8'h02));
        push(C_STOP); push(C_START); push(cw(8'hA1));
        push(cr(1'b0)); push(cr(1'b0)); push(cr(1'b1)); push(C_STOP);
        cmp_log("R6 R8 read stop-start");
        chk("R8 byte count", nrd, 3);
        chk("R8 byte0", int'(rdbuf[0]), 'hA0);
        chk("R8 byte1", int'(rdbuf[1]), 'hA1);
        chk("R8 byte2", int'(rdbuf[2]), 'hA2);
    endtask

    task automatic t_read_repeated();
        run(2'd1, 7'h68, 32'h0000_0010, 3'd1, 8'd1, 1'b1, 1'b0, 7'h0, 16'h0000, 1'b0);
        push(C_START); push(cw(8'hD0)); push(cw(8'h10));
        push(C_START); push(cw(8'hD1)); push(cr(1'b1)); push(C_STOP);
        cmp_log("R6 read repeated start");
        chk("R8 single byte", int'(rdbuf[0]), 'hA0);
    endtask

    task automatic t_read_no_addr();
        run(2'd1, 7'h50, 32'h0000_0099, 3'd0, 8'd2, 1'b0, 1'b0, 7'h0, 16'h0001, 1'b0);
        push(C_START); push(cw(8'hA1)); push(cr(1'b0)); push(cr(1'b1)); push(C_STOP);
        cmp_log("R7 R8 read zero length, address nack ignored");
        chk("R8 err", int'(c_err), 0);
        chk("R7 byte count", nrd, 2);
    endtask

    task automatic t_fold();
        run(2'd1, 7'h50, 32'h0000_0235, 3'd1, 8'd1, 1'b0, 1'b1, 7'h03, 16'h0000, 1'b0);
        push(C_START); push(cw(8'hA4)); push(cw(8'h35)); push(C_STOP);
        push(C_START); push(cw(8'hA5)); push(cr(1'b1)); push(C_STOP);
        cmp_log("R9 fold enabled");
        run(2'd1, 7'h50, 32'h0000_0235, 3'd1, 8'd1, 1'b0, 1'b0, 7'h03, 16'h0000, 1'b0);
        push(C_START); push(cw(8'hA0)); push(cw(8'h35)); push(C_STOP);
        push(C_START); push(cw(8'hA1)); push(cr(1'b1)); push(C_STOP);
        cmp_log("R9 fold disabled");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) wbytes[i] = 8'h00;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_probe_ack();
        t_probe_nack();
        t_write_basic();
        t_write_data_nack();
        t_write_dev_nack();
        t_write_reg_nack();
        t_write_zero();
        t_read_stop_start();
        t_read_repeated();
        t_read_no_addr();
        t_fold();
        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!fin) begin
            total++; bad++;
            $display("FAIL R11 global watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule